// File: doc/BRIEF.md
# Dual-Mode Port Status and Control Register

This block is one byte-wide register, mapped into the CPU's space, that controls a two-wire peripheral port. The port can carry low-speed USB or act as a PS/2-style open-drain link. Firmware sets three configuration flags: the keyboard-link pull-up request, the 3.3 V supply request, and the choice between a USB bus-reset interrupt and a PS/2 activity interrupt. It also writes a three-bit line-override code. The block holds a sticky flag that records bus activity. Only the serial link engine can set that flag, and only firmware can clear it.

The override code selects one of eight drive modes for the two data lines (D+ and D-). The modes are:
- `DRV_ENGINE`: the link engine's own value and enable pass through.
- `DRV_K`, `DRV_J`, `DRV_SE0`: push-pull forced USB line states.
- `OD_BOTH_LOW`, `OD_DM_LOW`, `OD_DP_LOW`, `OD_RELEASE`: open-drain modes, in which each line is either pulled low or released.

The drive mode is a state held in a register. There is one transition: on every clock edge, the mode moves to the mode decoded from the code then stored in the register. A write therefore reaches the lines one edge after it lands. Each tri-state line comes out as a separate value and output-enable.

Top module: `port_ctl_top`

## Requirements
- R1: After reset the read value is 0x00, every configuration output is 0, and all four line outputs (both values and both enables) are 0.
- R2: A write stores bit 7 (pull-up request), bit 6 (supply request), bit 5 (interrupt select: 1 selects the PS/2 activity interrupt) and bits 2:0 (override code). Each of these reads back at the same position.
- R3: A one-cycle activity strobe sets bit 3. Bit 3 then stays 1 with no write.
- R4: A write with bit 3 = 0 clears the activity flag. A write with bit 3 = 1 leaves the flag at its current value.
- R5: If an activity strobe and a write with bit 3 = 0 occur in the same cycle, the flag ends up 1.
- R6: Bit 4 always reads 0, whatever was written to it.
- R7: Code 000 passes the engine's D+ value, D- value and shared enable to the lines. Both line enables equal the engine enable.
- R8: Codes 001, 010 and 011 enable both lines and drive them as follows. 001 is K (D+ = 1, D- = 0). 010 is J (D+ = 0, D- = 1). 011 is SE0 (both 0).
- R9: When code bit 2 = 1, no line is ever driven high. D+ is released (enable 0) when code bit 0 = 1 and otherwise pulled low. D- is released when code bit 1 = 1 and otherwise pulled low. A released line shows value 0.
- R10: The line outputs are registered. After a write of a new code, the lines change at the next clock edge, not at the write edge.
- R11: The configuration outputs `pullup_en`, `supply_en`, `irq_sel_ps2` and `force_code` equal the stored fields as soon as the write edge has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Write strobe for the register |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Current register value |
| eng_activity | input | 1 | Non-idle bus event strobe from the link engine |
| eng_dp | input | 1 | Engine drive value for D+ |
| eng_dm | input | 1 | Engine drive value for D- |
| eng_oe | input | 1 | Engine output enable for both lines |
| dp_val | output | 1 | D+ drive value |
| dp_oe | output | 1 | D+ output enable |
| dm_val | output | 1 | D- drive value |
| dm_oe | output | 1 | D- output enable |
| pullup_en | output | 1 | PS/2 pull-up request |
| supply_en | output | 1 | 3.3 V supply request |
| irq_sel_ps2 | output | 1 | 1 selects the PS/2 activity interrupt, 0 the USB reset interrupt |
| force_code | output | 3 | Stored line-override code |

## Verification
A wrong stored field shows on the read port and on its configuration output at the first negative edge after the write. A bad activity flag shows there too, after the strobe or the clearing write. A wrong drive-mode decode shows one edge later on the four line outputs. In the open-drain modes, an error usually appears as a line driven high or enabled when it should be released. The bench sweeps all 256 write values against a running model of the flag. It then crosses all eight codes with all eight engine input patterns, so any wrong mode is seen within two cycles of its write.

// File: rtl/port_ctl_pkg.sv
package port_ctl_pkg;

    localparam int DATA_W   = 8;
    localparam int CODE_W   = 3;
    localparam int BIT_PU   = 7;
    localparam int BIT_SUP  = 6;
    localparam int BIT_IRQ  = 5;
    localparam int BIT_RSV  = 4;
    localparam int BIT_ACT  = 3;

    typedef enum logic [2:0] {
        DRV_ENGINE  = 3'd0,
        DRV_K       = 3'd1,
        DRV_J       = 3'd2,
        DRV_SE0     = 3'd3,
        OD_BOTH_LOW = 3'd4,
        OD_DM_LOW   = 3'd5,
        OD_DP_LOW   = 3'd6,
        OD_RELEASE  = 3'd7
    } drv_mode_t;

    typedef struct packed {
        logic dp_oe;
        logic dp_val;
        logic dm_oe;
        logic dm_val;
    } line_drv_t;

    localparam line_drv_t LINES_IDLE = '{dp_oe: 1'b0, dp_val: 1'b0, dm_oe: 1'b0, dm_val: 1'b0};

endpackage

// File: rtl/activity_flag.sv
module activity_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;
    logic flag_d;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) begin
            flag_d = 1'b0;
        end
        if (set_i) begin
            flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

    a_r3_strobe_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    a_r4_clear_when_asked: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    a_r3_no_spontaneous_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && flag_o) |=> flag_o);

endmodule

// File: rtl/ctl_reg.sv
module ctl_reg
    import port_ctl_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic          activity_i,
    output logic [W-1:0]  rdata_o,
    output logic          pullup_o,
    output logic          supply_o,
    output logic          irq_sel_o,
    output logic [CW-1:0] code_o
);

    logic          pu_q;
    logic          sup_q;
    logic          irq_q;
    logic [CW-1:0] code_q;
    logic          act_flag;
    logic          act_clr;

    assign act_clr = wr_i && !wdata_i[BIT_ACT];

    activity_flag u_act (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (activity_i),
        .clr_i  (act_clr),
        .flag_o (act_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pu_q   <= 1'b0;
            sup_q  <= 1'b0;
            irq_q  <= 1'b0;
            code_q <= '0;
        end else if (wr_i) begin
            pu_q   <= wdata_i[BIT_PU];
            sup_q  <= wdata_i[BIT_SUP];
            irq_q  <= wdata_i[BIT_IRQ];
            code_q <= wdata_i[CW-1:0];
        end
    end

    always_comb begin
        rdata_o           = '0;
        rdata_o[BIT_PU]   = pu_q;
        rdata_o[BIT_SUP]  = sup_q;
        rdata_o[BIT_IRQ]  = irq_q;
        rdata_o[BIT_RSV]  = 1'b0;
        rdata_o[BIT_ACT]  = act_flag;
        rdata_o[CW-1:0]   = code_q;
    end

    assign pullup_o  = pu_q;
    assign supply_o  = sup_q;
    assign irq_sel_o = irq_q;
    assign code_o    = code_q;

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (code_o == $past(wdata_i[CW-1:0])) && (pullup_o == $past(wdata_i[BIT_PU])));

    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(code_o) && $stable(irq_sel_o) && $stable(supply_o));

    a_r5_strobe_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (activity_i && act_clr) |=> rdata_o[BIT_ACT]);

endmodule

// File: rtl/line_drive.sv
module line_drive
    import port_ctl_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] code_i,
    input  logic          eng_dp_i,
    input  logic          eng_dm_i,
    input  logic          eng_oe_i,
    output line_drv_t     lines_o
);

    drv_mode_t mode;
    line_drv_t lines_d;
    line_drv_t lines_q;

    always_comb begin
        unique case (code_i)
            3'd0:    mode = DRV_ENGINE;
            3'd1:    mode = DRV_K;
            3'd2:    mode = DRV_J;
            3'd3:    mode = DRV_SE0;
            3'd4:    mode = OD_BOTH_LOW;
            3'd5:    mode = OD_DM_LOW;
            3'd6:    mode = OD_DP_LOW;
            default: mode = OD_RELEASE;
        endcase
    end

    always_comb begin
        lines_d = LINES_IDLE;
        unique case (mode)
            DRV_ENGINE: begin
                lines_d.dp_oe  = eng_oe_i;
                lines_d.dp_val = eng_dp_i;
                lines_d.dm_oe  = eng_oe_i;
                lines_d.dm_val = eng_dm_i;
            end
            DRV_K: begin
                lines_d.dp_oe  = 1'b1;
                lines_d.dp_val = 1'b1;
                lines_d.dm_oe  = 1'b1;
                lines_d.dm_val = 1'b0;
            end
            DRV_J: begin
                lines_d.dp_oe  = 1'b1;
                lines_d.dp_val = 1'b0;
                lines_d.dm_oe  = 1'b1;
                lines_d.dm_val = 1'b1;
            end
            DRV_SE0: begin
                lines_d.dp_oe  = 1'b1;
                lines_d.dm_oe  = 1'b1;
            end
            OD_BOTH_LOW: begin
                lines_d.dp_oe  = 1'b1;
                lines_d.dm_oe  = 1'b1;
            end
            OD_DM_LOW: begin
                lines_d.dm_oe  = 1'b1;
            end
            OD_DP_LOW: begin
                lines_d.dp_oe  = 1'b1;
            end
            OD_RELEASE: begin
                lines_d = LINES_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lines_q <= LINES_IDLE;
        end else begin
            lines_q <= lines_d;
        end
    end

    assign lines_o = lines_q;

    a_r9_open_drain_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        code_i[2] |=> !(lines_o.dp_oe && lines_o.dp_val) && !(lines_o.dm_oe && lines_o.dm_val));

    a_r8_se0_both_low: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == 3'd3) |=> lines_o.dp_oe && lines_o.dm_oe && !lines_o.dp_val && !lines_o.dm_val);

    a_r7_engine_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i == 3'd0) |=> (lines_o.dp_val == $past(eng_dp_i)) && (lines_o.dm_oe == $past(eng_oe_i)));

endmodule

// File: rtl/port_ctl_top.sv
module port_ctl_top
    import port_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_wr,
    input  logic [7:0] cpu_wdata,
    output logic [7:0] cpu_rdata,
    input  logic       eng_activity,
    input  logic       eng_dp,
    input  logic       eng_dm,
    input  logic       eng_oe,
    output logic       dp_val,
    output logic       dp_oe,
    output logic       dm_val,
    output logic       dm_oe,
    output logic       pullup_en,
    output logic       supply_en,
    output logic       irq_sel_ps2,
    output logic [2:0] force_code
);

    logic [CODE_W-1:0] code;
    line_drv_t         lines;

    ctl_reg #(.W(DATA_W), .CW(CODE_W)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (cpu_wr),
        .wdata_i    (cpu_wdata),
        .activity_i (eng_activity),
        .rdata_o    (cpu_rdata),
        .pullup_o   (pullup_en),
        .supply_o   (supply_en),
        .irq_sel_o  (irq_sel_ps2),
        .code_o     (code)
    );

    line_drive #(.CW(CODE_W)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_i   (code),
        .eng_dp_i (eng_dp),
        .eng_dm_i (eng_dm),
        .eng_oe_i (eng_oe),
        .lines_o  (lines)
    );

    assign force_code = code;
    assign dp_val     = lines.dp_val;
    assign dp_oe      = lines.dp_oe;
    assign dm_val     = lines.dm_val;
    assign dm_oe      = lines.dm_oe;

    a_r10_lines_lag_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_wdata[2:0] == 3'd7 && force_code == 3'd1) |=> dp_oe && dp_val);

endmodule

// File: tb/tb_port_ctl_top.sv
module tb_port_ctl_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       eng_activity = 1'b0;
    logic       eng_dp = 1'b0;
    logic       eng_dm = 1'b0;
    logic       eng_oe = 1'b0;
    logic       dp_val, dp_oe, dm_val, dm_oe;
    logic       pullup_en, supply_en, irq_sel_ps2;
    logic [2:0] force_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic model_flag = 1'b0;

    always #10 clk = ~clk;

    port_ctl_top dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .eng_activity(eng_activity), .eng_dp(eng_dp),
        .eng_dm(eng_dm), .eng_oe(eng_oe), .dp_val(dp_val), .dp_oe(dp_oe),
        .dm_val(dm_val), .dm_oe(dm_oe), .pullup_en(pullup_en),
        .supply_en(supply_en), .irq_sel_ps2(irq_sel_ps2), .force_code(force_code)
    );

    function automatic logic [3:0] exp_lines(input logic [2:0] c, input logic edp,
                                             input logic edm, input logic eoe);
        if (c[2]) return {~c[0], 1'b0, ~c[1], 1'b0};
        case (c)
            3'd0:    return {eoe, edp, eoe, edm};
            3'd1:    return 4'b1110;
            3'd2:    return 4'b1011;
            default: return 4'b1010;
        endcase
    endfunction

    function automatic logic [3:0] act_lines();
        return {dp_oe, dp_val, dm_oe, dm_val};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] d, input logic strobe);
        @(negedge clk);
        cpu_wr = 1'b1;
        cpu_wdata = d;
        eng_activity = strobe;
        @(negedge clk);
        cpu_wr = 1'b0;
        eng_activity = 1'b0;
    endtask

    task automatic pulse_activity();
        @(negedge clk);
        eng_activity = 1'b1;
        @(negedge clk);
        eng_activity = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rdata", cpu_rdata, 8'h00);
        chk("R1 cfg", {4'h0, pullup_en, supply_en, irq_sel_ps2, 1'b0} | {5'h0, force_code}, 8'h00);
        chk("R1 lines", {4'h0, act_lines()}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R6 R11: every write value against a running flag model
        for (int v = 0; v < 256; v++) begin
            if (v % 3 == 0) begin
                pulse_activity();
                model_flag = 1'b1;
            end
            write_reg(v[7:0], 1'b0);
            if (!v[3]) model_flag = 1'b0;
            chk("R2/R4/R6 readback", cpu_rdata, (v[7:0] & 8'hE7) | {4'h0, model_flag, 3'b000});
            chk("R11 cfg outputs", {pullup_en, supply_en, irq_sel_ps2, 2'b00, force_code},
                {v[7], v[6], v[5], 2'b00, v[2:0]});
        end

        // R3: strobe sets, flag holds with no write
        write_reg(8'h00, 1'b0);
        chk("R3 cleared first", {7'h0, cpu_rdata[3]}, 8'h00);
        pulse_activity();
        chk("R3 set by strobe", {7'h0, cpu_rdata[3]}, 8'h01);
        repeat (5) @(negedge clk);
        chk("R3 holds", {7'h0, cpu_rdata[3]}, 8'h01);
        write_reg(8'h08, 1'b0);
        chk("R4 write1 preserves", {7'h0, cpu_rdata[3]}, 8'h01);

        // R5: strobe and clearing write together
        write_reg(8'h00, 1'b1);
        chk("R5 strobe wins", {7'h0, cpu_rdata[3]}, 8'h01);
        write_reg(8'h10, 1'b0);
        chk("R6 reserved reads 0", cpu_rdata, 8'h00);

        // R10: lines lag the write by one edge
        eng_dp = 1'b0; eng_dm = 1'b0; eng_oe = 1'b0;
        @(negedge clk);
        write_reg(8'h01, 1'b0);
        chk("R10 lines still old", {4'h0, act_lines()}, 8'h00);
        @(negedge clk);
        chk("R10 lines new", {4'h0, act_lines()}, 8'h0E);

        // R7 R8 R9: every code against every engine pattern
        for (int c = 0; c < 8; c++) begin
            write_reg({5'h0, c[2:0]}, 1'b0);
            for (int e = 0; e < 8; e++) begin
                eng_dp = e[0]; eng_dm = e[1]; eng_oe = e[2];
                @(negedge clk);
                chk(c == 0 ? "R7 engine pass" : (c < 4 ? "R8 forced state" : "R9 open drain"),
                    {4'h0, act_lines()}, {4'h0, exp_lines(c[2:0], e[0], e[1], e[2])});
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule